// File: doc/BRIEF.md
# Multi-Width Serial SRAM Slave

This block is the device side of a byte-wide serial memory. It runs on the serial clock while chip select is low. Each transaction starts with an 8-bit opcode. Memory accesses then carry a 24-bit address, and after that an unbounded stream of data bytes. The internal 17-bit pointer steps after every byte, so a host can read or fill the whole space with a single command. Every field travels most significant bit first.

The link can be one, two or four lanes wide. Opcodes switch the width. The chosen width stays in force across later transactions until a return-to-single opcode or a reset clears it. In the two wide modes, opcode, address and data all use the wide lanes. A fixed number of idle clocks, set by the width, separates the address from the first read data. The data pins are split into an input vector, an output vector and a per-lane drive enable, so the pad ring can build the shared bidirectional bus. An 8-bit general register can be loaded and read back with its own pair of opcodes. The storage array is internal. It is indexed by the low bits of the pointer, so a smaller array repeats across the 17-bit space.

Top module: `mwsram_top`

## Requirements
- R1: Opcode, address and write data are sampled on the rising `sclk` edge, MSB first. Read data changes only on the falling edge, so each bit stays stable across the following rising edge.
- R2: Opcode 03h followed by a 24-bit address returns the byte stored at that address, then the following bytes, for as long as chip select stays low.
- R3: Opcode 02h followed by a 24-bit address stores each complete received byte at the pointer, then steps the pointer by one.
- R4: Address bits 23..17 are ignored. The pointer wraps from 1FFFFh to 00000h, and the array is indexed by the pointer's low bits.
- R5: Before read data, the block inserts 4 idle clocks in two-lane mode and 2 in four-lane mode, with every drive enable low. Single-lane mode has none.
- R6: Opcode 3Bh selects two-lane mode, 38h selects four-lane mode and FFh selects single-lane mode. The change takes effect from the next transaction and persists across chip-select cycles. Reset selects single-lane mode.
- R7: Lane mapping. Single-lane mode receives on lane 0 and drives only lane 1 (enable 0010b). Two-lane mode uses lanes 1..0 with the MSB on lane 1 (enable 0011b). Four-lane mode uses lanes 3..0 with the MSB on lane 3 (enable 1111b).
- R8: While chip select is high, all drive enables are low at once, without waiting for a clock edge. The transaction is abandoned, and a write byte that is still incomplete is discarded.
- R9: Opcode 01h loads the next byte into the mode register. Opcode 05h returns that register, repeated for as long as clocks continue. The register resets to 00h.
- R10: Any other opcode makes the rest of the transaction ignored. The memory, the width and the register are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sio_in | input | 4 | Data lanes as seen at the pads |
| sio_out | output | 4 | Data driven toward the pads |
| sio_oe | output | 4 | Per-lane drive enable |

## Verification
The bench checks the idle-clock count in each wide mode by reading data right after the expected number of idle clocks. A design that inserts too few or too many returns data shifted by whole lane groups, and it raises a drive enable during the gap. The bench checks that a width persists by switching once and then running several separate transactions. A width that falls back to single lane at chip select would garble every later field. A half-sent write byte, an unknown opcode that is followed by a valid-looking width opcode, and a chip-select release in the middle of a read each catch a design that writes partial data, decodes bytes after the opcode, or keeps driving after deselect. Streaming across the top of the pointer range checks that the pointer continues at zero.

// File: rtl/mwsram_pkg.sv
package mwsram_pkg;

    typedef enum logic [1:0] {
        LW_ONE  = 2'd0,
        LW_TWO  = 2'd1,
        LW_FOUR = 2'd2
    } lane_mode_e;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_GAP,
        ST_RD,
        ST_WR,
        ST_REGWR,
        ST_SKIP
    } seq_st_e;

    localparam int ADDR_FIELD_W = 24;

    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_WRITE = 8'h02;
    localparam logic [7:0] OPC_FOUR  = 8'h38;
    localparam logic [7:0] OPC_TWO   = 8'h3B;
    localparam logic [7:0] OPC_ONE   = 8'hFF;
    localparam logic [7:0] OPC_REGRD = 8'h05;
    localparam logic [7:0] OPC_REGWR = 8'h01;

    function automatic logic [2:0] bits_per_clk(lane_mode_e m);
        case (m)
            LW_TWO:  return 3'd2;
            LW_FOUR: return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    function automatic logic [2:0] gap_clocks(lane_mode_e m);
        case (m)
            LW_TWO:  return 3'd4;
            LW_FOUR: return 3'd2;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/mwsram_array.sv
module mwsram_array
    import mwsram_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rdata
);

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[widx] <= wdata;
    end

    assign rdata = cells[ridx];

endmodule

// File: rtl/mwsram_lanes.sv
module mwsram_lanes
    import mwsram_pkg::*;
(
    input  logic       sclk,
    input  logic       rst,
    input  logic       cs_n,
    input  lane_mode_e mode,
    input  logic       drive,
    input  logic [7:0] tx_byte,
    input  logic [3:0] tx_cnt,
    input  logic [3:0] sio_in,
    output logic [3:0] in_bits,
    output logic [3:0] sio_out,
    output logic [3:0] sio_oe
);

    logic [3:0] out_q, oe_q;
    logic [7:0] sel;

    always_comb begin
        case (mode)
            LW_TWO:  in_bits = {2'b00, sio_in[1:0]};
            LW_FOUR: in_bits = sio_in;
            default: in_bits = {3'b000, sio_in[0]};
        endcase
    end

    assign sel = tx_byte << tx_cnt;

    always_ff @(negedge sclk) begin
        if (rst || cs_n || !drive) begin
            out_q <= 4'h0;
            oe_q  <= 4'h0;
        end else begin
            case (mode)
                LW_TWO: begin
                    out_q <= {2'b00, sel[7:6]};
                    oe_q  <= 4'b0011;
                end
                LW_FOUR: begin
                    out_q <= sel[7:4];
                    oe_q  <= 4'b1111;
                end
                default: begin
                    out_q <= {2'b00, sel[7], 1'b0};
                    oe_q  <= 4'b0010;
                end
            endcase
        end
    end

    assign sio_out = out_q;
    assign sio_oe  = oe_q & {4{~cs_n}};

endmodule

// File: rtl/mwsram_ctrl.sv
module mwsram_ctrl
    import mwsram_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int IDX_W  = 8
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic [3:0]        in_bits,
    input  logic [7:0]        rd_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              we,
    output logic [IDX_W-1:0]  w_idx,
    output logic [7:0]        w_data,
    output lane_mode_e        mode,
    output seq_st_e           st,
    output logic [ADDR_W-1:0] ptr,
    output logic [7:0]        mreg,
    output logic              drive,
    output logic [7:0]        tx_byte,
    output logic [3:0]        tx_cnt
);

    lane_mode_e              mode_q;
    seq_st_e                 st_q;
    logic [4:0]              cnt_q;
    logic [ADDR_FIELD_W-1:0] sh_q;
    logic [ADDR_W-1:0]       ptr_q;
    logic [7:0]              txb_q, mreg_q;
    logic [3:0]              txc_q;
    logic [2:0]              gap_q;
    logic                    from_reg_q, is_read_q;

    logic [2:0]              bw;
    logic [4:0]              cnt_nxt;
    logic [3:0]              txc_nxt;
    logic [ADDR_FIELD_W-1:0] sh_nxt;
    logic [ADDR_W-1:0]       ptr_inc, rd_ptr;

    assign bw      = bits_per_clk(mode_q);
    assign cnt_nxt = cnt_q + 5'(bw);
    assign txc_nxt = txc_q + 4'(bw);
    assign sh_nxt  = (sh_q << bw) | ADDR_FIELD_W'(in_bits);
    assign ptr_inc = ptr_q + 1'b1;

    always_comb begin
        case (st_q)
            ST_ADDR: rd_ptr = sh_nxt[ADDR_W-1:0];
            ST_RD:   rd_ptr = ptr_inc;
            default: rd_ptr = ptr_q;
        endcase
    end

    assign rd_idx = rd_ptr[IDX_W-1:0];
    assign we     = !cs_n && st_q == ST_WR && cnt_nxt == 5'd8;
    assign w_idx  = ptr_q[IDX_W-1:0];
    assign w_data = sh_nxt[7:0];

    always_ff @(posedge sclk) begin
        if (rst) begin
            mode_q     <= LW_ONE;
            st_q       <= ST_CMD;
            cnt_q      <= '0;
            sh_q       <= '0;
            ptr_q      <= '0;
            txb_q      <= '0;
            txc_q      <= '0;
            gap_q      <= '0;
            mreg_q     <= '0;
            from_reg_q <= 1'b0;
            is_read_q  <= 1'b0;
        end else if (cs_n) begin
            st_q  <= ST_CMD;
            cnt_q <= '0;
            txc_q <= '0;
            gap_q <= '0;
        end else begin
            case (st_q)
                ST_CMD: begin
                    sh_q  <= sh_nxt;
                    cnt_q <= cnt_nxt;
                    if (cnt_nxt == 5'd8) begin
                        cnt_q <= '0;
                        case (sh_nxt[7:0])
                            OPC_READ:  begin is_read_q <= 1'b1; st_q <= ST_ADDR; end
                            OPC_WRITE: begin is_read_q <= 1'b0; st_q <= ST_ADDR; end
                            OPC_FOUR:  begin mode_q <= LW_FOUR; st_q <= ST_SKIP; end
                            OPC_TWO:   begin mode_q <= LW_TWO;  st_q <= ST_SKIP; end
                            OPC_ONE:   begin mode_q <= LW_ONE;  st_q <= ST_SKIP; end
                            OPC_REGRD: begin
                                from_reg_q <= 1'b1;
                                txb_q      <= mreg_q;
                                txc_q      <= '0;
                                st_q       <= ST_RD;
                            end
                            OPC_REGWR: st_q <= ST_REGWR;
                            default:   st_q <= ST_SKIP;
                        endcase
                    end
                end
                ST_ADDR: begin
                    sh_q  <= sh_nxt;
                    cnt_q <= cnt_nxt;
                    if (cnt_nxt == 5'(ADDR_FIELD_W)) begin
                        cnt_q <= '0;
                        ptr_q <= sh_nxt[ADDR_W-1:0];
                        if (!is_read_q) begin
                            st_q <= ST_WR;
                        end else if (gap_clocks(mode_q) == 3'd0) begin
                            from_reg_q <= 1'b0;
                            txb_q      <= rd_data;
                            txc_q      <= '0;
                            st_q       <= ST_RD;
                        end else begin
                            gap_q <= '0;
                            st_q  <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    gap_q <= gap_q + 3'd1;
                    if (gap_q == gap_clocks(mode_q) - 3'd1) begin
                        from_reg_q <= 1'b0;
                        txb_q      <= rd_data;
                        txc_q      <= '0;
                        st_q       <= ST_RD;
                    end
                end
                ST_RD: begin
                    txc_q <= txc_nxt;
                    if (txc_nxt == 4'd8) begin
                        txc_q <= '0;
                        if (from_reg_q) begin
                            txb_q <= mreg_q;
                        end else begin
                            ptr_q <= ptr_inc;
                            txb_q <= rd_data;
                        end
                    end
                end
                ST_WR: begin
                    sh_q  <= sh_nxt;
                    cnt_q <= cnt_nxt;
                    if (cnt_nxt == 5'd8) begin
                        cnt_q <= '0;
                        ptr_q <= ptr_inc;
                    end
                end
                ST_REGWR: begin
                    sh_q  <= sh_nxt;
                    cnt_q <= cnt_nxt;
                    if (cnt_nxt == 5'd8) begin
                        mreg_q <= sh_nxt[7:0];
                        st_q   <= ST_SKIP;
                    end
                end
                default: ;
            endcase
        end
    end

    assign mode    = mode_q;
    assign st      = st_q;
    assign ptr     = ptr_q;
    assign mreg    = mreg_q;
    assign drive   = (st_q == ST_RD);
    assign tx_byte = txb_q;
    assign tx_cnt  = txc_q;

endmodule

// File: rtl/mwsram_top.sv
module mwsram_top
    import mwsram_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int MEM_DEPTH = 256,
    localparam int IDX_W    = $clog2(MEM_DEPTH)
) (
    input  logic       sclk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic [3:0] sio_in,
    output logic [3:0] sio_out,
    output logic [3:0] sio_oe
);

    lane_mode_e        mode_w;
    seq_st_e           st_w;
    logic [ADDR_W-1:0] ptr_w;
    logic [7:0]        mreg_w, rd_data, w_data, tx_byte;
    logic [IDX_W-1:0]  rd_idx, w_idx;
    logic [3:0]        in_bits, tx_cnt;
    logic              we, drive;

    mwsram_lanes u_lanes (
        .sclk(sclk), .rst(rst), .cs_n(cs_n), .mode(mode_w), .drive(drive),
        .tx_byte(tx_byte), .tx_cnt(tx_cnt), .sio_in(sio_in),
        .in_bits(in_bits), .sio_out(sio_out), .sio_oe(sio_oe)
    );

    mwsram_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
        .sclk(sclk), .rst(rst), .cs_n(cs_n), .in_bits(in_bits),
        .rd_data(rd_data), .rd_idx(rd_idx), .we(we), .w_idx(w_idx),
        .w_data(w_data), .mode(mode_w), .st(st_w), .ptr(ptr_w),
        .mreg(mreg_w), .drive(drive), .tx_byte(tx_byte), .tx_cnt(tx_cnt)
    );

    mwsram_array #(.DEPTH(MEM_DEPTH)) u_array (
        .clk(sclk), .we(we), .widx(w_idx), .wdata(w_data),
        .ridx(rd_idx), .rdata(rd_data)
    );

endmodule

// File: rtl/mwsram_chk.sv
module mwsram_chk
    import mwsram_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input logic              sclk,
    input logic              rst,
    input logic              cs_n,
    input logic [3:0]        sio_oe,
    input lane_mode_e        mode_w,
    input seq_st_e           st_w,
    input logic [ADDR_W-1:0] ptr_w,
    input logic [7:0]        mreg_w
);

    AST_OE_LEGAL: assert property (@(negedge sclk) disable iff (rst)
        (sio_oe == 4'b0000 || sio_oe == 4'b0010 || sio_oe == 4'b0011 || sio_oe == 4'b1111)); // R7

    AST_GAP_QUIET: assert property (@(posedge sclk) disable iff (rst)
        (st_w == ST_GAP) |-> (sio_oe == 4'b0000)); // R5

    AST_PTR_WRAP: assert property (@(posedge sclk) disable iff (rst)
        (($past(st_w) == ST_RD || $past(st_w) == ST_WR) && $past(ptr_w) == {ADDR_W{1'b1}}
         && ptr_w != {ADDR_W{1'b1}}) |-> (ptr_w == '0)); // R4

    AST_MODE_AT_OPCODE: assert property (@(posedge sclk) disable iff (rst)
        (mode_w != $past(mode_w)) |-> ($past(st_w) == ST_CMD)); // R6

    AST_DESEL_RESTART: assert property (@(posedge sclk) disable iff (rst)
        cs_n |=> (st_w == ST_CMD)); // R8

    AST_REG_ONLY_BY_OPCODE: assert property (@(posedge sclk) disable iff (rst)
        (mreg_w != $past(mreg_w)) |-> ($past(st_w) == ST_REGWR)); // R9

endmodule

bind mwsram_top mwsram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .sclk(sclk), .rst(rst), .cs_n(cs_n), .sio_oe(sio_oe),
    .mode_w(mode_w), .st_w(st_w), .ptr_w(ptr_w), .mreg_w(mreg_w)
);

// File: tb/sim_mwsram_top.sv
`timescale 1ns/1ps
module sim_mwsram_top;

    logic       sclk = 1'b0;
    logic       rst  = 1'b1;
    logic       cs_n = 1'b1;
    logic [3:0] sio_in = 4'h0;
    logic [3:0] sio_out, sio_oe;

    int n_chk  = 0;
    int n_fail = 0;
    int bw     = 1;
    bit done   = 1'b0;

    mwsram_top u0 (
        .sclk(sclk), .rst(rst), .cs_n(cs_n),
        .sio_in(sio_in), .sio_out(sio_out), .sio_oe(sio_oe)
    );

    always #2.5 sclk = ~sclk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] v);
        sio_in = v;
        @(negedge sclk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int k = 0; k < 8; k += bw)
            step(4'((b >> (8 - bw - k)) & ((1 << bw) - 1)));
    endtask

    task automatic send_addr(input logic [23:0] a);
        send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
    endtask

    task automatic recv_byte(output logic [7:0] b, output logic [3:0] oe);
        b = '0;
        oe = '0;
        for (int k = 0; k < 8; k += bw) begin
            #1;
            if (k == 0) oe = sio_oe;
            case (bw)
                1: b = {b[6:0], sio_out[1]};
                2: b = {b[5:0], sio_out[1:0]};
                default: b = {b[3:0], sio_out};
            endcase
            sio_in = 4'h0;
            @(negedge sclk);
        end
    endtask

    task automatic end_tx;
        cs_n = 1'b1;
        sio_in = 4'h0;
        @(negedge sclk);
        @(negedge sclk);
    endtask

    task automatic wr_bytes(input logic [23:0] a, input logic [7:0] d[]);
        cs_n = 1'b0;
        send_byte(8'h02);
        send_addr(a);
        foreach (d[i]) send_byte(d[i]);
        end_tx();
    endtask

    task automatic rd_check(input string req, input logic [23:0] a, input logic [7:0] exp[],
                            input logic [3:0] exp_oe);
        logic [7:0] b;
        logic [3:0] oe;
        cs_n = 1'b0;
        send_byte(8'h03);
        send_addr(a);
        if (bw == 2 || bw == 4) begin
            for (int g = 0; g < (bw == 2 ? 4 : 2); g++) begin
                #1;
                chk("R5 drive off during idle clocks", 32'(sio_oe), 32'h0);
                step(4'h0);
            end
        end
        foreach (exp[i]) begin
            recv_byte(b, oe);
            chk(req, 32'(b), 32'(exp[i]));
            chk("R7 lane enables", 32'(oe), 32'(exp_oe));
        end
        end_tx();
    endtask

    task automatic t_reset_and_reg;
        logic [7:0] b;
        logic [3:0] oe;
        chk("R8 enables low after reset", 32'(sio_oe), 32'h0);
        cs_n = 1'b0; send_byte(8'h05); recv_byte(b, oe); end_tx();
        chk("R9 register reset value", 32'(b), 32'h00);
        chk("R7 single lane enable", 32'(oe), 32'h2);
        cs_n = 1'b0; send_byte(8'h01); send_byte(8'h5A); end_tx();
        cs_n = 1'b0; send_byte(8'h05); recv_byte(b, oe);
        chk("R9 register readback", 32'(b), 32'h5A);
        recv_byte(b, oe);
        chk("R9 register repeats", 32'(b), 32'h5A);
        end_tx();
    endtask

    task automatic t_single_stream;
        wr_bytes(24'h000010, '{8'h3C, 8'h4D, 8'h5E});
        rd_check("R2 R3 R1 single-lane stream", 24'h000010, '{8'h3C, 8'h4D, 8'h5E}, 4'b0010);
    endtask

    task automatic t_dual;
        cs_n = 1'b0; send_byte(8'h3B); end_tx();
        bw = 2;
        wr_bytes(24'h000140, '{8'hA1, 8'hB2, 8'hC3});
        rd_check("R6 R5 two-lane stream", 24'h000140, '{8'hA1, 8'hB2, 8'hC3}, 4'b0011);
        rd_check("R6 two-lane persists", 24'h000010, '{8'h3C}, 4'b0011);
    endtask

    task automatic t_quad_wrap;
        cs_n = 1'b0; send_byte(8'h38); end_tx();
        bw = 4;
        wr_bytes(24'h01FFFF, '{8'hD4, 8'hE5});
        rd_check("R4 wrap stream", 24'h01FFFF, '{8'hD4, 8'hE5}, 4'b1111);
        rd_check("R4 wrap landed at zero", 24'h000000, '{8'hE5}, 4'b1111);
        rd_check("R4 upper address bits ignored", 24'hFE0140, '{8'hA1}, 4'b1111);
    endtask

    task automatic t_back_to_single;
        cs_n = 1'b0; send_byte(8'hFF); end_tx();
        bw = 1;
        rd_check("R6 return to single lane", 24'h000140, '{8'hA1, 8'hB2}, 4'b0010);
    endtask

    task automatic t_unknown_opcode;
        cs_n = 1'b0; send_byte(8'hA5); send_byte(8'h38); send_byte(8'h02); end_tx();
        rd_check("R10 unknown opcode ignored", 24'h000140, '{8'hA1}, 4'b0010);
    endtask

    task automatic t_partial_and_desel;
        logic [7:0] b;
        logic [3:0] oe;
        wr_bytes(24'h000020, '{8'h11, 8'h77});
        cs_n = 1'b0; send_byte(8'h02); send_addr(24'h000021);
        repeat (4) step(4'h1);
        end_tx();
        rd_check("R8 partial byte discarded", 24'h000020, '{8'h11, 8'h77}, 4'b0010);
        cs_n = 1'b0; send_byte(8'h03); send_addr(24'h000020);
        recv_byte(b, oe);
        chk("R2 read before deselect", 32'(b), 32'h11);
        #1;
        chk("R7 driving before deselect", 32'(sio_oe), 32'h2);
        cs_n = 1'b1;
        #0.5;
        chk("R8 deselect releases lanes at once", 32'(sio_oe), 32'h0);
        @(negedge sclk);
        end_tx();
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge sclk);
        rst = 1'b0;
        @(negedge sclk);
        t_reset_and_reg();
        t_single_stream();
        t_dual();
        t_quad_wrap();
        t_back_to_single();
        t_unknown_opcode();
        t_partial_and_desel();
        finish_run();
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule